// File: doc/BRIEF.md
# Frame-select serial port master

This block is the master side of a synchronous serial link that moves one data word per frame. It pulls an active-low frame select, toggles a serial clock, shifts the transmit word out most significant bit first and gathers the receive bit stream into a parallel word. The word length can be anything from 4 to 32 bits. Two static inputs choose the idle level of the clock and where data changes relative to the clock edges, which gives four signalling modes.

On the parallel side, a one-cycle load strobe starts a frame, provided the port is enabled and no frame is running. A busy output covers the whole frame. The received word appears right-aligned with a one-cycle valid pulse as the frame closes. After a frame the transmit line keeps the last bit that was sent. When the port is disabled the transmit line is driven low and any frame in progress is dropped. The divider input sets the length of half a serial clock period in system clocks.

Top module: `spi_frame_master`

## Requirements
- R1: A load strobe accepted while `enable` is high and `busy` is low pulls `frm_n` low and raises `busy` on the next clock. Both stay that way until the frame ends. A load strobe that arrives while `busy` is high is ignored and does not change the word being sent.
- R2: The word length is taken from `word_len` as a bit count N. Values below 4 are treated as 4 and values above 32 as 32. The low N bits of `tx_data` go out on `mosi`, most significant first.
- R3: Outside a frame, `sclk` equals `cpol`. Within a frame, `sclk` makes exactly 2N transitions. A leading edge is the change away from `cpol`.
- R4: With `cpha` = 0, the first leading edge comes 2H system clocks after `frm_n` falls. `miso` is sampled on leading edges and `mosi` changes on trailing edges. `frm_n` rises H clocks after the last trailing edge. The frame lasts (2N+2)·H clocks.
- R5: With `cpha` = 1, the first leading edge comes H clocks after `frm_n` falls. `mosi` changes on leading edges and `miso` is sampled on trailing edges. `frm_n` rises H clocks after the last edge. The frame lasts (2N+1)·H clocks.
- R6: H, the half period of `sclk` in system clocks, equals `clk_div`. A `clk_div` of 0 is treated as 1.
- R7: In the clock where `frm_n` returns high at the end of a frame, `rx_valid` is high for exactly one cycle. At that time `rx_data` holds the N sampled bits, right-aligned, with the first-sampled bit in position N-1 and zeros above.
- R8: Between frames, while enabled, `mosi` keeps the last bit sent, which is bit 0 of the word.
- R9: While `enable` is low, `mosi` is low, load strobes are ignored and no frame runs. Clearing `enable` during a frame ends it on the next clock with `frm_n` high and no `rx_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Port enable; low forces `mosi` low and aborts a frame |
| cpol | input | 1 | Idle level of `sclk` |
| cpha | input | 1 | Clock phase: 0 samples on leading edges, 1 samples on trailing edges |
| word_len | input | 6 | Bits per frame (clamped to 4..32) |
| clk_div | input | 8 | Half period of `sclk` in system clocks (0 acts as 1) |
| tx_load | input | 1 | One-cycle strobe that starts a frame |
| tx_data | input | 32 | Word to send, right-aligned |
| busy | output | 1 | High from an accepted load until the frame ends |
| rx_valid | output | 1 | One-cycle pulse with the received word |
| rx_data | output | 32 | Received word, right-aligned and zero-extended |
| frm_n | output | 1 | Frame select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial transmit data |
| miso | input | 1 | Serial receive data |

## Verification
The hardest part to check from the ports is the exact placement of the first and the last clock edge relative to the frame select, in every phase and polarity mode and at several divider values. An error of a single system clock there does not change any data bit. The bench therefore runs a slave model that reacts to every `sclk` transition it sees. The model counts the quiet system clocks before the first edge and after the last edge, and also counts the frame length. Random frames cover all four modes, lengths from 4 to 32 and dividers from 0 to 4. Directed cases add clamped lengths, a load strobe issued in the middle of a frame, and a disable during a frame.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_LEAD,
    EV_TRAIL,
    EV_END
  } spi_ev_e;

  // Bit count actually used for a frame.
  function automatic int unsigned clamp_len(int unsigned raw, int unsigned max_bits);
    if (raw < 4) return 4;
    if (raw > max_bits) return max_bits;
    return raw;
  endfunction

  // Half period of the serial clock in system clocks.
  function automatic int unsigned half_period(int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  // Half-period ticks from frame start to release.
  function automatic int unsigned frame_ticks(int unsigned n, logic pha);
    return 2 * n + (pha ? 1 : 2);
  endfunction

  // Phase-normalised tick index: leading edges fall on odd values.
  function automatic int unsigned norm_tick(int unsigned t, logic pha);
    return pha ? t : t - 1;
  endfunction

  // What happens at half-period tick t (t >= 1) of an n-bit frame.
  function automatic spi_ev_e decode_tick(int unsigned t, logic pha, int unsigned n);
    int unsigned u;
    u = norm_tick(t, pha);
    if (u == 2 * n + 1) return EV_END;
    if (u >= 1 && u <= 2 * n) return u[0] ? EV_LEAD : EV_TRAIL;
    return EV_NONE;
  endfunction

  function automatic logic is_final_trail(int unsigned t, logic pha, int unsigned n);
    return norm_tick(t, pha) == 2 * n;
  endfunction

endpackage

// File: rtl/spi_fm_divider.sv
module spi_fm_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && !restart && (cnt == half - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || !run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

endmodule

// File: rtl/spi_fm_sequencer.sv
module spi_fm_sequencer
  import spi_fm_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             tick,
  input  logic             pha,
  input  logic [LEN_W-1:0] nbits,
  output spi_ev_e          ev,
  output logic             final_trail
);

  logic [CNT_W-1:0] t_q;
  logic [CNT_W-1:0] t_nx;

  assign t_nx = t_q + CNT_W'(1);

  always_comb begin
    ev          = EV_NONE;
    final_trail = 1'b0;
    if (tick) begin
      ev          = decode_tick(32'(t_nx), pha, 32'(nbits));
      final_trail = is_final_trail(32'(t_nx), pha, 32'(nbits));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '0;
    end else if (start || abort) begin
      t_q <= '0;
    end else if (tick) begin
      t_q <= t_nx;
    end
  end

endmodule

// File: rtl/spi_fm_shifter.sv
module spi_fm_shifter #(
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                load,
  input  logic                pha,
  input  logic [LEN_W-1:0]    nbits,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic                shift_out,
  input  logic                sample_in,
  input  logic                miso,
  output logic                mosi,
  output logic [MAX_BITS-1:0] rx_word
);

  logic [MAX_BITS-1:0] tx_sh;
  logic [MAX_BITS-1:0] aligned;
  logic [LEN_W-1:0]    pad;

  // Left-align the word so the first bit out is always the top bit.
  assign pad     = LEN_W'(MAX_BITS) - nbits;
  assign aligned = tx_word << pad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      mosi  <= 1'b0;
    end else if (clear) begin
      mosi <= 1'b0;
    end else if (load) begin
      if (pha) begin
        tx_sh <= aligned;
      end else begin
        mosi  <= aligned[MAX_BITS-1];
        tx_sh <= aligned << 1;
      end
    end else if (shift_out) begin
      mosi  <= tx_sh[MAX_BITS-1];
      tx_sh <= tx_sh << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word <= '0;
    end else if (load) begin
      rx_word <= '0;
    end else if (sample_in) begin
      rx_word <= {rx_word[MAX_BITS-2:0], miso};
    end
  end

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_fm_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int DIV_W    = 8,
  localparam int LEN_W   = $clog2(MAX_BITS + 1),
  localparam int CNT_W   = $clog2(2 * MAX_BITS + 3)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                cpol,
  input  logic                cpha,
  input  logic [LEN_W-1:0]    word_len,
  input  logic [DIV_W-1:0]    clk_div,
  input  logic                tx_load,
  input  logic [MAX_BITS-1:0] tx_data,
  output logic                busy,
  output logic                rx_valid,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                frm_n,
  output logic                sclk,
  output logic                mosi,
  input  logic                miso
);

  logic             busy_q;
  logic             pha_q;
  logic             pol_q;
  logic             ph_q;
  logic [LEN_W-1:0] len_q;
  logic [DIV_W-1:0] half_q;
  logic [LEN_W-1:0] len_now;
  logic             rxv_q;
  logic [MAX_BITS-1:0] rxd_q;

  // Named internal events.
  logic    start_w;
  logic    abort_w;
  logic    tick_w;
  spi_ev_e ev_w;
  logic    final_trail_w;
  logic    lead_w;
  logic    trail_w;
  logic    end_w;
  logic    shift_w;
  logic    sample_w;
  logic [MAX_BITS-1:0] rx_word_w;

  assign start_w  = enable && tx_load && !busy_q;
  assign abort_w  = !enable && busy_q;
  assign len_now  = LEN_W'(clamp_len(32'(word_len), MAX_BITS));
  assign lead_w   = (ev_w == EV_LEAD);
  assign trail_w  = (ev_w == EV_TRAIL);
  assign end_w    = (ev_w == EV_END);
  assign shift_w  = pha_q ? lead_w : (trail_w && !final_trail_w);
  assign sample_w = pha_q ? trail_w : lead_w;

  spi_fm_divider #(
    .DIV_W (DIV_W)
  ) u_divider (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy_q),
    .restart (start_w),
    .half    (half_q),
    .tick    (tick_w)
  );

  spi_fm_sequencer #(
    .CNT_W (CNT_W),
    .LEN_W (LEN_W)
  ) u_sequencer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_w),
    .abort       (abort_w),
    .tick        (tick_w),
    .pha         (pha_q),
    .nbits       (len_q),
    .ev          (ev_w),
    .final_trail (final_trail_w)
  );

  spi_fm_shifter #(
    .MAX_BITS (MAX_BITS),
    .LEN_W    (LEN_W)
  ) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (!enable),
    .load      (start_w),
    .pha       (cpha),
    .nbits     (len_now),
    .tx_word   (tx_data),
    .shift_out (shift_w),
    .sample_in (sample_w),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_word_w)
  );

  // Frame configuration, captured at the accepted load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pha_q  <= 1'b0;
      pol_q  <= 1'b0;
      len_q  <= LEN_W'(4);
      half_q <= DIV_W'(1);
    end else if (start_w) begin
      pha_q  <= cpha;
      pol_q  <= cpol;
      len_q  <= len_now;
      half_q <= DIV_W'(half_period(32'(clk_div)));
    end
  end

  // Frame and clock phase state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
    end else if (start_w) begin
      busy_q <= 1'b1;
      ph_q   <= 1'b0;
    end else if (abort_w || end_w) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
    end else if (lead_w) begin
      ph_q <= 1'b1;
    end else if (trail_w) begin
      ph_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxv_q <= 1'b0;
      rxd_q <= '0;
    end else begin
      rxv_q <= end_w && enable;
      if (end_w && enable) begin
        rxd_q <= rx_word_w;
      end
    end
  end

  assign busy     = busy_q;
  assign frm_n    = !busy_q;
  assign sclk     = busy_q ? (pol_q ^ ph_q) : cpol;
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;

endmodule

// File: rtl/spi_fm_checker.sv
module spi_fm_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic cpol,
  input logic tx_load,
  input logic busy,
  input logic rx_valid,
  input logic frm_n,
  input logic sclk,
  input logic mosi
);

  assert_load_opens_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tx_load && !busy) |=> (!frm_n && busy));

  assert_idle_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frm_n |-> (sclk == cpol));

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_valid_at_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $rose(frm_n));

  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_n && $past(frm_n) && $past(enable)) |-> $stable(mosi));

  assert_disable_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!mosi && !busy));

endmodule

bind spi_frame_master spi_fm_checker u_spi_fm_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .cpol     (cpol),
  .tx_load  (tx_load),
  .busy     (busy),
  .rx_valid (rx_valid),
  .frm_n    (frm_n),
  .sclk     (sclk),
  .mosi     (mosi)
);

// File: tb/test_spi_frame_master.sv
`timescale 1ns/1ps
module test_spi_frame_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cpol = 1'b0;
  logic        cpha = 1'b0;
  logic [5:0]  word_len = 6'd8;
  logic [7:0]  clk_div = 8'd1;
  logic        tx_load = 1'b0;
  logic [31:0] tx_data = '0;
  logic        busy;
  logic        rx_valid;
  logic [31:0] rx_data;
  logic        frm_n;
  logic        sclk;
  logic        mosi;
  logic        miso = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_frame_master i_spi_frame_master (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .cpol     (cpol),
    .cpha     (cpha),
    .word_len (word_len),
    .clk_div  (clk_div),
    .tx_load  (tx_load),
    .tx_data  (tx_data),
    .busy     (busy),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .frm_n    (frm_n),
    .sclk     (sclk),
    .mosi     (mosi),
    .miso     (miso)
  );

  function automatic int exp_len(int raw);
    return (raw < 4) ? 4 : ((raw > 32) ? 32 : raw);
  endfunction

  function automatic int exp_half(int raw);
    return (raw < 1) ? 1 : raw;
  endfunction

  function automatic logic [31:0] low_mask(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One frame with a slave model reacting to every clock transition.
  task automatic run_frame(int len, bit pol, bit pha, int div,
                           logic [31:0] tx, logic [31:0] sw, bit poke);
    int n, h, sb, iter, low, edges, pre, since, vcount;
    bit seen, prev;
    logic [31:0] got, rxd, mask;
    string rq;
    n = exp_len(len);
    h = exp_half(div);
    mask = low_mask(n);
    rq = pha ? "R5" : "R4";
    @(negedge clk);
    word_len = 6'(len);
    cpol = pol;
    cpha = pha;
    clk_div = 8'(div);
    tx_data = tx;
    sb = n - 1;
    if (!pha) begin
      miso = sw[sb];
      sb--;
    end
    @(negedge clk);
    chk(sclk == pol, "R3", "idle sclk before frame", sclk, pol);
    tx_load = 1'b1;
    iter = 0; low = 0; edges = 0; pre = 0; since = 0; vcount = 0;
    seen = 0; prev = pol; got = '0; rxd = '0;
    forever begin
      @(negedge clk);
      iter++;
      if (iter == 1) tx_load = 1'b0;
      if (poke && iter == 3) begin
        tx_data = ~tx;
        tx_load = 1'b1;
      end
      if (poke && iter == 4) tx_load = 1'b0;
      if (iter == 1) chk(!frm_n && busy, "R1", "frame open after load", {frm_n, busy}, 2'b01);
      if (!frm_n) low++;
      if (sclk != prev) begin
        edges++;
        seen = 1;
        since = 1;
        if (sclk != pol) begin
          if (!pha) got = {got[30:0], mosi};
          else if (sb >= 0) begin miso = sw[sb]; sb--; end
        end else begin
          if (pha) got = {got[30:0], mosi};
          else if (sb >= 0) begin miso = sw[sb]; sb--; end
        end
      end else if (!frm_n) begin
        if (!seen) pre++;
        else since++;
      end
      prev = sclk;
      if (rx_valid) begin
        vcount++;
        rxd = rx_data;
        chk(frm_n, "R7", "valid with frame released", frm_n, 1);
      end else if (vcount > 0) begin
        break;
      end
      if (iter > 4000) begin
        chk(0, "R1", "frame never ended", iter, 0);
        break;
      end
    end
    chk(got == (tx & mask), "R2", "bits seen on mosi", got, tx & mask);
    chk(rxd == (sw & mask), "R7", "received word", rxd, sw & mask);
    chk(vcount == 1, "R7", "valid pulse width", vcount, 1);
    chk(edges == 2 * n, "R3", "sclk transitions", edges, 2 * n);
    chk(low == (2 * n + (pha ? 1 : 2)) * h, rq, "frame length", low, (2 * n + (pha ? 1 : 2)) * h);
    chk(pre == (pha ? 1 : 2) * h, rq, "quiet clocks before first edge", pre, (pha ? 1 : 2) * h);
    chk(since == h, (div == 0) ? "R6" : rq, "quiet clocks after last edge", since, h);
    chk(mosi == tx[0] && !busy, "R8", "mosi holds lsb after frame", mosi, tx[0]);
  endtask

  initial begin
    int guard;
    guard = 0;
    while (!done && guard < 150000) begin
      @(posedge clk);
      guard++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=%0d expected=0", guard);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(frm_n && !busy && !rx_valid, "R1", "reset frame state", {frm_n, busy, rx_valid}, 3'b100);
    chk(mosi == 1'b0, "R9", "reset mosi", mosi, 0);
    rst_n = 1'b1;
    @(negedge clk);
    enable = 1'b1;

    // Directed cases across modes and boundaries.
    run_frame(8, 0, 0, 1, 32'h0000_00A5, 32'h0000_003C, 0);
    run_frame(8, 1, 1, 2, 32'h0000_005A, 32'h0000_00C3, 0);
    run_frame(32, 0, 1, 3, 32'hDEAD_BEEF, 32'h1234_5678, 0);
    run_frame(32, 1, 0, 1, 32'h8000_0001, 32'hFFFF_FFFF, 0);
    run_frame(4, 1, 0, 0, 32'hFFFF_FFF6, 32'hFFFF_FFF9, 0);   // R6 divider 0
    run_frame(2, 0, 0, 1, 32'h0000_000B, 32'h0000_0006, 0);   // R2 clamp up to 4
    run_frame(40, 0, 1, 1, 32'hC0FF_EE11, 32'h0F0F_0F0F, 0);  // R2 clamp down to 32
    run_frame(12, 0, 0, 2, 32'h0000_0ABC, 32'h0000_0555, 1);  // R1 load while busy

    // Random frames.
    for (int k = 0; k < 24; k++) begin
      a = $urandom();
      b = $urandom();
      run_frame(4 + int'($urandom_range(28)), 1'($urandom_range(1)),
                1'($urandom_range(1)), int'($urandom_range(4)), a, b, 0);
    end

    // R9: disable during a frame.
    @(negedge clk);
    word_len = 6'd16; cpol = 1'b1; cpha = 1'b0; clk_div = 8'd4; tx_data = 32'h0000_FFFF;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    repeat (10) @(negedge clk);
    chk(!frm_n && busy, "R9", "frame running before disable", frm_n, 0);
    enable = 1'b0;
    @(negedge clk);
    chk(frm_n && !busy, "R9", "disable ends frame", {frm_n, busy}, 2'b10);
    chk(mosi == 1'b0, "R9", "mosi low when disabled", mosi, 0);
    chk(sclk == cpol, "R9", "sclk idle after abort", sclk, cpol);
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    begin
      int bad;
      bad = 0;
      repeat (40) begin
        @(negedge clk);
        if (!frm_n || busy || rx_valid || mosi) bad++;
      end
      chk(bad == 0, "R9", "load ignored while disabled", bad, 0);
    end
    enable = 1'b1;
    run_frame(6, 0, 1, 1, 32'h0000_0029, 32'h0000_0016, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule